// File: doc/BRIEF.md
# Pruned Tree Binary-to-BCD Converter

This block turns an unsigned binary word into packed binary-coded decimal without any clock. It uses the shift-and-add-3 method, but it does not lay down a full rectangle of correction cells. Each column of the array holds a correction cell only for the decimal digits that can reach five or more at that point in the conversion. Every other digit is wired straight through. The array is therefore triangular: it gains one extra row of cells for every three further input bits.

The input width is a parameter. The output width is derived from it as the smallest width that holds the decimal form of the largest input. The most significant digit is cut down to the bits it can actually reach, so bits that are always zero never appear at the port. A display or formatting stage downstream takes the digits it needs from the bottom of the output.

Top module: `bin2bcd_tree`

## Requirements
- R1: Digit d of the output occupies bits [4d+3:4d], with digit 0 (units) in bits [3:0]. The decimal value read from the output equals the input value for every input.
- R2: Every complete 4-bit digit of the output holds a value from 0 to 9.
- R3: The output width is 4·(D−1) plus the bits needed for the largest top digit, where D is the number of decimal digits of 2^N−1. Examples: N=4 gives 5, N=16 gives 19 and N=24 gives 29.
- R4: For N of 3 or less the output equals the input bit for bit.
- R5: For widths up to 10 bits the conversion is correct for every possible input value.
- R6: An all-zero input gives an all-zero output, and the all-ones input gives the exact decimal form of 2^N−1.
- R7: The output follows the input with no clock. A new input value is fully converted within the same time step, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin | input | N | Unsigned binary value |
| bcd | output | M (derived from N) | Packed BCD result, units digit lowest, top digit truncated |

## Verification
The hardest conditions to reach are the ones where the highest correction rows fire. This happens only when the input is large enough that its top digit reaches five at an inner column, which random values for wide inputs seldom do with the right digit patterns. It also matters in the pruned top digit, where the all-ones value must land exactly. Narrow instances are therefore swept exhaustively, so that every correction cell sees every carry pattern. Wide instances get the all-zero and all-ones values forced, plus random values, and each digit is compared with repeated division by ten.

// File: rtl/bin2bcd_pkg.sv
// Package: constant functions shared by the converter and its checker.
// Assumes N between 1 and 62 so that 2^N-1 fits a longint.
package bin2bcd_pkg;

    // Number of decimal digits needed for 2^n-1.
    function automatic int dec_digits(input int n);
        longint mx;
        int     d;
        mx = (longint'(1) <<< n) - 1;
        d  = 1;
        while (mx >= 10) begin
            mx = mx / 10;
            d  = d + 1;
        end
        return d;
    endfunction

    // Largest value the top decimal digit of 2^n-1 can reach.
    function automatic int top_digit_max(input int n);
        longint mx;
        mx = (longint'(1) <<< n) - 1;
        while (mx >= 10) mx = mx / 10;
        return int'(mx);
    endfunction

    // Output width: full lower digits plus the truncated top digit.
    function automatic int bcd_width(input int n);
        return 4 * (dec_digits(n) - 1) + $clog2(top_digit_max(n) + 1);
    endfunction

    // True when digit d can hold 5 or more after k bits have been shifted in.
    function automatic bit cell_needed(input int k, input int d);
        longint mx;
        longint p;
        mx = (longint'(1) <<< k) - 1;
        p  = 5;
        for (int i = 0; i < d; i++) p = p * 10;
        return mx >= p;
    endfunction

endpackage

// File: rtl/bin2bcd_add3.sv
// Module: single correction cell. Adds 3 to a digit of 5 or more and
// passes smaller digits through. Assumes the input digit is at most 9.
module bin2bcd_add3 (
    input  logic [3:0] dig_in,
    output logic [3:0] dig_out
);

    // Conditional add-3 correction.
    always_comb begin
        if (dig_in >= 4'd5) dig_out = dig_in + 4'd3;
        else                dig_out = dig_in;
    end

endmodule

// File: rtl/bin2bcd_column.sv
// Module: one column of the tree. Corrects only the digits that can reach
// 5 or more after K bits, then shifts left, taking in the next input bit.
// Assumes din holds a valid BCD value below 2^K.
module bin2bcd_column #(
    parameter int K  = 3,
    parameter int ND = 1
) (
    input  logic [4*ND-1:0] din,
    input  logic            sin,
    output logic [4*ND-1:0] dout
);

    localparam int W = 4 * ND;

    logic [W-1:0] adj;

    // Per-digit choice between a correction cell and a plain wire.
    for (genvar d = 0; d < ND; d++) begin : g_dig
        if (bin2bcd_pkg::cell_needed(K, d)) begin : g_cell
            bin2bcd_add3 u_add3 (
                .dig_in (din[4*d +: 4]),
                .dig_out(adj[4*d +: 4])
            );
        end else begin : g_wire
            assign adj[4*d +: 4] = din[4*d +: 4];
        end
    end

    // Shift one place toward the top and insert the next binary bit.
    assign dout = {adj[W-2:0], sin};

endmodule

// File: rtl/bin2bcd_tree.sv
// Module: top of the pruned shift-and-add-3 converter. Builds N-3 columns
// whose cell count grows with the bits already consumed. The output is cut
// to the derived width M. Purely combinational, with no clock or reset.
module bin2bcd_tree #(
    parameter int N = 24
) (
    input  logic [N-1:0]                          bin,
    output logic [bin2bcd_pkg::bcd_width(N)-1:0]  bcd
);

    localparam int M = bin2bcd_pkg::bcd_width(N);
    localparam int D = bin2bcd_pkg::dec_digits(N);
    localparam int W = 4 * D;

    if (N <= 3) begin : g_short
        // Values below 8 are already valid single BCD digits.
        assign bcd = bin;
    end else begin : g_tree
        logic [W-1:0] stage [0:N-3];

        // Seed with the top three bits, which need no correction yet.
        assign stage[0] = {{(W-3){1'b0}}, bin[N-1 -: 3]};

        for (genvar j = 0; j < N - 3; j++) begin : g_col
            bin2bcd_column #(
                .K (j + 3),
                .ND(D)
            ) u_col (
                .din (stage[j]),
                .sin (bin[N-4-j]),
                .dout(stage[j+1])
            );
        end

        // Keep only the bits the value can reach.
        assign bcd = stage[N-3][M-1:0];
    end

endmodule

// File: rtl/bin2bcd_tree_chk.sv
// Module: checker bound to the converter. Decodes the output digits and
// relates them to the input value. Immediate checks in combinational scope.
module bin2bcd_tree_chk #(
    parameter int N = 24,
    parameter int M = 29
) (
    input logic [N-1:0] bin,
    input logic [M-1:0] bcd
);

    localparam int D    = bin2bcd_pkg::dec_digits(N);
    localparam int TOPM = bin2bcd_pkg::top_digit_max(N);

    logic [4*D-1:0] full;
    assign full = {{(4*D-M){1'b0}}, bcd};

    // Digit range, decoded value, top digit and short-width pass-through.
    always_comb begin
        longint acc;
        longint p;
        acc = 0;
        p   = 1;
        for (int d = 0; d < D; d++) begin
            assert_digit_range_R2: assert (full[4*d +: 4] <= 4'd9)
                else $error("digit %0d out of range", d);
            acc = acc + longint'(full[4*d +: 4]) * p;
            p   = p * 10;
        end
        assert_value_match_R1: assert (acc == longint'(bin))
            else $error("decoded %0d differs from input %0d", acc, bin);
        assert_top_digit_R3: assert (int'(full[4*(D-1) +: 4]) <= TOPM)
            else $error("top digit above its reachable maximum");
        assert_zero_in_R6: assert ((bin != '0) || (bcd == '0))
            else $error("zero input gave nonzero output");
        if (N <= 3) begin
            assert_passthrough_R4: assert (bcd == M'(bin))
                else $error("short width not passed through");
        end
    end

endmodule

bind bin2bcd_tree bin2bcd_tree_chk #(.N(N), .M(M)) u_chk (.bin(bin), .bcd(bcd));

// File: tb/bin2bcd_tree_test.sv
// Bench: several widths side by side. A behavioural model (division by ten)
// is compared with every instance once per clock, sampled on the falling edge.
module bin2bcd_tree_test;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    logic [0:0]  in1;
    logic [2:0]  in3;
    logic [3:0]  in4;
    logic [6:0]  in7;
    logic [9:0]  in10;
    logic [15:0] in16;
    logic [23:0] uin;

    logic [bin2bcd_pkg::bcd_width(1)-1:0]  o1;
    logic [bin2bcd_pkg::bcd_width(3)-1:0]  o3;
    logic [bin2bcd_pkg::bcd_width(4)-1:0]  o4;
    logic [bin2bcd_pkg::bcd_width(7)-1:0]  o7;
    logic [bin2bcd_pkg::bcd_width(10)-1:0] o10;
    logic [bin2bcd_pkg::bcd_width(16)-1:0] o16;
    logic [bin2bcd_pkg::bcd_width(24)-1:0] uout;

    bin2bcd_tree #(.N(1))  uut_n1  (.bin(in1),  .bcd(o1));
    bin2bcd_tree #(.N(3))  uut_n3  (.bin(in3),  .bcd(o3));
    bin2bcd_tree #(.N(4))  uut_n4  (.bin(in4),  .bcd(o4));
    bin2bcd_tree #(.N(7))  uut_n7  (.bin(in7),  .bcd(o7));
    bin2bcd_tree #(.N(10)) uut_n10 (.bin(in10), .bcd(o10));
    bin2bcd_tree #(.N(16)) uut_n16 (.bin(in16), .bcd(o16));
    bin2bcd_tree #(.N(24)) uut     (.bin(uin),  .bcd(uout));

    // Reference: decimal digits by repeated division, packed 4 bits each.
    function automatic logic [63:0] ref_bcd(input longint v);
        logic [63:0] r;
        longint      x;
        r = '0;
        x = v;
        for (int d = 0; d < 16; d++) begin
            r[4*d +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int n, input int m,
                       input longint v, input logic [63:0] got);
        logic [63:0] exp;
        logic [63:0] mask;
        exp  = ref_bcd(v);
        mask = (m >= 64) ? '1 : ((64'd1 << m) - 1);
        total++;
        if ((got & mask) != (exp & mask) || (exp & ~mask) != 0) begin
            bad++;
            $display("FAIL %s N=%0d in=%0d got=%h exp=%h", tag, n, v, got & mask, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Digit range check on the widest instance (R2).
    task automatic chk_digits_r2(input logic [28:0] v);
        for (int d = 0; d < 7; d++) begin
            total++;
            if (v[4*d +: 4] > 4'd9) begin
                bad++;
                $display("FAIL R2 digit %0d got=%0d exp<=9", d, v[4*d +: 4]);
            end
        end
    endtask

    task automatic drive(input int it);
        in1  = it[0:0];
        in3  = it[2:0];
        in4  = it[3:0];
        in7  = it[6:0];
        in10 = it[9:0];
        if (it == 0) begin
            in16 = '0;
            uin  = '0;
        end else if (it == 1) begin
            in16 = '1;
            uin  = '1;
        end else if (it == 2) begin
            in16 = 16'd59999;
            uin  = 24'd9999999;
        end else begin
            in16 = 16'($urandom);
            uin  = 24'($urandom);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints a summary.
    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R3: derived output widths.
        chk_int("R3 width N=1",  $bits(o1),   1);
        chk_int("R3 width N=3",  $bits(o3),   3);
        chk_int("R3 width N=4",  $bits(o4),   5);
        chk_int("R3 width N=16", $bits(o16),  19);
        chk_int("R3 width N=24", $bits(uout), 29);

        // R7: a new value is converted at once, with no clock edge in between.
        uin = 24'd123456;
        #1;
        chk("R7 no-clock", 24, 29, 123456, 64'(uout));

        for (int it = 0; it < 1024; it++) begin
            @(posedge clk);
            drive(it);
            @(negedge clk);
            // R4: short widths pass through unchanged.
            chk("R4 N=1", 1, 1, longint'(in1), 64'(o1));
            chk("R4 N=3", 3, 3, longint'(in3), 64'(o3));
            // R5: exhaustive sweep of narrow widths; R1 digit placement.
            chk("R5 N=4",  4,  5,  longint'(in4),  64'(o4));
            chk("R5 N=7",  7,  $bits(o7),  longint'(in7),  64'(o7));
            chk("R5 N=10", 10, $bits(o10), longint'(in10), 64'(o10));
            if (it < 2) begin
                // R6: all-zero and all-ones values on the wide instances.
                chk("R6 N=16", 16, 19, longint'(in16), 64'(o16));
                chk("R6 N=24", 24, 29, longint'(uin),  64'(uout));
            end else begin
                chk("R1 N=16", 16, 19, longint'(in16), 64'(o16));
                chk("R1 N=24", 24, 29, longint'(uin),  64'(uout));
            end
            chk_digits_r2(uout);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule